// File: doc/BRIEF.md
# Split-Byte Sample Read Controller

This is a host-side sequencer for a 16-bit sampling converter whose result has to be fetched over an 8-bit path. Only the upper eight data lines of the converter are wired to the host. When the consumer signals `ready`, the controller selects the device and pulses the start strobe. It then waits for the converter's activity flag to rise and fall again. After that it fetches the result in two accesses on the same eight lines. With the half-select low the access yields the upper byte. With the half-select high it yields the lower byte.

The two bytes are joined into a 16-bit word, which appears on `smp_data` for a single cycle of `smp_valid`. The read strobe can work in one of two ways, chosen by a parameter. In the first, it pulses once for each byte. In the second, it stays low through both bytes while the half-select toggles. Each byte is sampled a set number of clocks after the strobe or half-select changes, which leaves time for the bus access.

The first three results read after reset are calibration results and are never reported. Device select and start only ever fall while the converter is idle, because a falling edge on either during a conversion would abort it. A timeout flags a converter that does not finish.

Top module: `byte_adc_reader`

## Requirements
- R1: During and directly after reset, `start_n`, `dev_sel_n` and `oe_n` are 1, `half_sel` is 0, and `smp_valid` and `tmo_err` are 0.
- R2: While `ready` is 0 and the controller is idle (`dev_sel_n` = 1), no conversion is started and `dev_sel_n` stays 1.
- R3: `dev_sel_n` and `start_n` fall only in cycles where `conv_active` is 0.
- R4: Each sample is read in two accesses. The first has `half_sel` = 0 and the byte on `dq_hi` becomes `smp_data[15:8]`. The second has `half_sel` = 1 and the byte on `dq_hi` becomes `smp_data[7:0]`.
- R5: A byte is sampled exactly SETTLE clock edges after the `oe_n` / `half_sel` change that begins its access, so data that settles within SETTLE-1 cycles is captured correctly.
- R6: With HOLD_RD = 0, `oe_n` has two separate low pulses per sample and is 1 when `half_sel` rises. With HOLD_RD = 1, `oe_n` falls once per sample and is 0 when `half_sel` rises.
- R7: The first DISCARD (default 3) completed reads after reset give no `smp_valid` pulse. Every later read gives one.
- R8: `smp_valid` is high for exactly one cycle per reported sample.
- R9: If the converter has not finished within TIMEOUT cycles of the end of the start pulse, `tmo_err` pulses for one cycle and the controller returns to idle (`dev_sel_n` = 1) without any read access. After that it serves the next request normally.
- R10: `oe_n` is 0 only while `dev_sel_n` is 0 and `conv_active` is 0.
- R11: `start_n` is low for exactly CONV_W cycles per conversion, and only while `dev_sel_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready | input | 1 | Consumer can accept a new sample; needed to start a conversion |
| conv_active | input | 1 | Converter is converting (high) |
| dq_hi | input | 8 | Upper eight converter data lines |
| start_n | output | 1 | Conversion start strobe, active low |
| dev_sel_n | output | 1 | Device select, active low |
| oe_n | output | 1 | Read strobe, active low |
| half_sel | output | 1 | 0 = upper byte on dq_hi, 1 = lower byte on dq_hi |
| smp_valid | output | 1 | One-cycle pulse marking a reported sample |
| smp_data | output | 16 | Assembled sample |
| tmo_err | output | 1 | One-cycle pulse on conversion timeout |

## Verification
The properties take for granted that `conv_active` rises only in response to a start pulse and otherwise stays low, so a check on the select and start edges reflects only the controller's choices. The bench keeps within this through a converter model that raises its flag one cycle after it sees the start strobe fall and drops it after a fixed conversion time, or, in the timeout scenario, later on command while the controller is idle. The model drives the data lines with a filler byte until the access has been stable for two cycles. It also counts every forbidden select, start or read edge it observes during a conversion. `ready` is lowered only after a conversion has begun, so exactly one sample is taken for each scenario step.

// File: rtl/byte_adc_pkg.sv
package byte_adc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_PULSE,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_RD_HI,
        ST_RD_GAP,
        ST_RD_LO,
        ST_DONE
    } rd_state_e;

    typedef struct packed {
        logic start_n;
        logic dev_sel_n;
        logic oe_n;
        logic half_sel;
    } pin_set_t;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } word_t;

    localparam pin_set_t PINS_IDLE = '{start_n: 1'b1, dev_sel_n: 1'b1, oe_n: 1'b1, half_sel: 1'b0};

    function automatic pin_set_t pins_for(rd_state_e s);
        pin_set_t p;
        p = PINS_IDLE;
        case (s)
            ST_IDLE:    p = PINS_IDLE;
            ST_SEL:     p.dev_sel_n = 1'b0;
            ST_PULSE: begin
                p.dev_sel_n = 1'b0;
                p.start_n   = 1'b0;
            end
            ST_WAIT_HI,
            ST_WAIT_LO: p.dev_sel_n = 1'b0;
            ST_RD_HI: begin
                p.dev_sel_n = 1'b0;
                p.oe_n      = 1'b0;
            end
            ST_RD_GAP: begin
                p.dev_sel_n = 1'b0;
                p.half_sel  = 1'b1;
            end
            ST_RD_LO: begin
                p.dev_sel_n = 1'b0;
                p.oe_n      = 1'b0;
                p.half_sel  = 1'b1;
            end
            ST_DONE:    p.dev_sel_n = 1'b0;
            default:    p = PINS_IDLE;
        endcase
        return p;
    endfunction

    function automatic logic [15:0] join_bytes(word_t w);
        return {w.hi, w.lo};
    endfunction

endpackage

// File: rtl/step_timer.sv
module step_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/word_pack.sv
module word_pack
    import byte_adc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_hi,
    input  logic        cap_lo,
    input  logic [7:0]  dq,
    output logic [15:0] word
);
    word_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else begin
            if (cap_hi) held.hi <= dq;
            if (cap_lo) held.lo <= dq;
        end
    end

    assign word = join_bytes(held);
endmodule

// File: rtl/warmup_gate.sv
module warmup_gate #(
    parameter int DISCARD = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fin,
    input  logic [15:0] word,
    output logic        valid,
    output logic [15:0] data
);
    localparam int DW = $clog2(DISCARD + 2);

    logic [DW-1:0] seen;
    logic          warm;

    assign warm = (seen == DW'(DISCARD));

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= '0;
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= fin && warm;
            if (fin && !warm) seen <= seen + DW'(1);
            if (fin && warm)  data <= word;
        end
    end
endmodule

// File: rtl/ctl_fsm.sv
module ctl_fsm
    import byte_adc_pkg::*;
#(
    parameter int HOLD_RD = 0,
    parameter int SETTLE  = 4,
    parameter int CONV_W  = 3,
    parameter int TW      = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ready,
    input  logic          conv_active,
    input  logic          t_done,
    input  logic          to_done,
    output pin_set_t      pins,
    output logic          t_clr,
    output logic [TW-1:0] t_limit,
    output logic          to_clr,
    output logic          cap_hi,
    output logic          cap_lo,
    output logic          fin,
    output logic          tmo_err
);
    rd_state_e state_q, state_d;
    logic      err_d;

    always_comb begin
        state_d = state_q;
        err_d   = 1'b0;
        cap_hi  = 1'b0;
        cap_lo  = 1'b0;
        fin     = 1'b0;
        case (state_q)
            ST_IDLE:    if (ready && !conv_active) state_d = ST_SEL;
            ST_SEL:     state_d = ST_PULSE;
            ST_PULSE:   if (t_done) state_d = ST_WAIT_HI;
            ST_WAIT_HI: begin
                if (conv_active) begin
                    state_d = ST_WAIT_LO;
                end else if (to_done) begin
                    state_d = ST_IDLE;
                    err_d   = 1'b1;
                end
            end
            ST_WAIT_LO: begin
                if (!conv_active) begin
                    state_d = ST_RD_HI;
                end else if (to_done) begin
                    state_d = ST_IDLE;
                    err_d   = 1'b1;
                end
            end
            ST_RD_HI: begin
                if (t_done) begin
                    cap_hi  = 1'b1;
                    state_d = (HOLD_RD != 0) ? ST_RD_LO : ST_RD_GAP;
                end
            end
            ST_RD_GAP:  state_d = ST_RD_LO;
            ST_RD_LO: begin
                if (t_done) begin
                    cap_lo  = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                fin     = 1'b1;
                state_d = ST_IDLE;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    assign t_clr   = (state_d != state_q);
    assign t_limit = (state_q == ST_PULSE) ? TW'(CONV_W - 1) : TW'(SETTLE - 1);
    assign to_clr  = !((state_q == ST_WAIT_HI) || (state_q == ST_WAIT_LO));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins    <= PINS_IDLE;
            tmo_err <= 1'b0;
        end else begin
            state_q <= state_d;
            pins    <= pins_for(state_d);
            tmo_err <= err_d;
        end
    end
endmodule

// File: rtl/byte_adc_reader.sv
module byte_adc_reader
    import byte_adc_pkg::*;
#(
    parameter int HOLD_RD = 0,
    parameter int SETTLE  = 4,
    parameter int CONV_W  = 3,
    parameter int TIMEOUT = 1000,
    parameter int DISCARD = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ready,
    input  logic        conv_active,
    input  logic [7:0]  dq_hi,
    output logic        start_n,
    output logic        dev_sel_n,
    output logic        oe_n,
    output logic        half_sel,
    output logic        smp_valid,
    output logic [15:0] smp_data,
    output logic        tmo_err
);
    localparam int TMAX = (SETTLE > CONV_W) ? SETTLE : CONV_W;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int TOW  = $clog2(TIMEOUT + 1);

    pin_set_t      pins;
    logic          t_clr, t_done, to_clr, to_done;
    logic [TW-1:0] t_limit;
    logic          cap_hi, cap_lo, fin;
    logic [15:0]   word;

    ctl_fsm #(
        .HOLD_RD (HOLD_RD),
        .SETTLE  (SETTLE),
        .CONV_W  (CONV_W),
        .TW      (TW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ready       (ready),
        .conv_active (conv_active),
        .t_done      (t_done),
        .to_done     (to_done),
        .pins        (pins),
        .t_clr       (t_clr),
        .t_limit     (t_limit),
        .to_clr      (to_clr),
        .cap_hi      (cap_hi),
        .cap_lo      (cap_lo),
        .fin         (fin),
        .tmo_err     (tmo_err)
    );

    step_timer #(.W(TW)) u_step (
        .clk   (clk),
        .rst   (rst),
        .clr   (t_clr),
        .limit (t_limit),
        .done  (t_done)
    );

    step_timer #(.W(TOW)) u_tmo (
        .clk   (clk),
        .rst   (rst),
        .clr   (to_clr),
        .limit (TOW'(TIMEOUT - 1)),
        .done  (to_done)
    );

    word_pack u_pack (
        .clk    (clk),
        .rst    (rst),
        .cap_hi (cap_hi),
        .cap_lo (cap_lo),
        .dq     (dq_hi),
        .word   (word)
    );

    warmup_gate #(.DISCARD(DISCARD)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .fin   (fin),
        .word  (word),
        .valid (smp_valid),
        .data  (smp_data)
    );

    assign start_n   = pins.start_n;
    assign dev_sel_n = pins.dev_sel_n;
    assign oe_n      = pins.oe_n;
    assign half_sel  = pins.half_sel;
endmodule

// File: rtl/byte_adc_reader_chk.sv
module byte_adc_reader_chk #(
    parameter int HOLD_RD = 0
) (
    input logic clk,
    input logic rst,
    input logic ready,
    input logic conv_active,
    input logic start_n,
    input logic dev_sel_n,
    input logic oe_n,
    input logic half_sel,
    input logic smp_valid,
    input logic tmo_err
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (start_n && dev_sel_n && oe_n && !half_sel && !smp_valid && !tmo_err));

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_sel_n && !ready) |=> dev_sel_n);

    // R3
    sel_edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dev_sel_n) |-> !conv_active);

    // R3
    start_edge_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(start_n) |-> !conv_active);

    // R6
    strobe_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((HOLD_RD != 0) && $rose(half_sel)) |-> !oe_n);

    // R6
    strobe_mode_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ((HOLD_RD == 0) && $rose(half_sel)) |-> oe_n);

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    // R9
    tmo_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_err |=> !tmo_err);

    // R9
    tmo_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_err |-> (dev_sel_n && oe_n && !smp_valid));

    // R10
    read_window_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (!dev_sel_n && !conv_active));

    // R11
    start_selected_chk: assert property (@(posedge clk) disable iff (rst)
        !start_n |-> !dev_sel_n);
endmodule

bind byte_adc_reader byte_adc_reader_chk #(.HOLD_RD(HOLD_RD)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ready       (ready),
    .conv_active (conv_active),
    .start_n     (start_n),
    .dev_sel_n   (dev_sel_n),
    .oe_n        (oe_n),
    .half_sel    (half_sel),
    .smp_valid   (smp_valid),
    .tmo_err     (tmo_err)
);

// File: tb/adc_model.sv
module adc_model #(
    parameter int CONV_CYC = 20,
    parameter int DLY      = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_n,
    input  logic        dev_sel_n,
    input  logic        oe_n,
    input  logic        half_sel,
    input  logic        stuck,
    input  logic [15:0] word_in,
    output logic        conv_active,
    output logic [7:0]  dq_hi,
    output int          conv_cnt,
    output int          oe_falls,
    output int          viol,
    output int          last_w
);
    logic        p_start, p_sel, p_oe, p_half;
    logic [15:0] res;
    int          age, cyc, wcnt;
    int          v_add;

    always_comb begin
        v_add = 0;
        if (p_start && !start_n && conv_active) v_add = v_add + 1;
        if (p_sel && !dev_sel_n && conv_active) v_add = v_add + 1;
        if (p_oe && !oe_n && conv_active)       v_add = v_add + 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_start <= 1'b1; p_sel <= 1'b1; p_oe <= 1'b1; p_half <= 1'b0;
            conv_active <= 1'b0;
            res <= '0; age <= 0; cyc <= 0; wcnt <= 0;
            conv_cnt <= 0; oe_falls <= 0; viol <= 0; last_w <= 0;
        end else begin
            p_start <= start_n; p_sel <= dev_sel_n; p_oe <= oe_n; p_half <= half_sel;
            viol <= viol + v_add;
            if (p_start && !start_n && !conv_active && !dev_sel_n) begin
                conv_active <= 1'b1;
                cyc         <= 0;
                res         <= word_in;
                conv_cnt    <= conv_cnt + 1;
            end else if (conv_active && !stuck) begin
                cyc <= cyc + 1;
                if (cyc >= CONV_CYC - 1) conv_active <= 1'b0;
            end
            if (p_oe && !oe_n) oe_falls <= oe_falls + 1;
            if (!start_n) begin
                wcnt <= wcnt + 1;
            end else if (!p_start) begin
                last_w <= wcnt;
                wcnt   <= 0;
            end
            if ((oe_n != p_oe) || (half_sel != p_half)) age <= 0;
            else if (age < 255) age <= age + 1;
        end
    end

    assign dq_hi = (oe_n || dev_sel_n) ? 8'h00 :
                   (age < DLY)         ? 8'hA5 :
                   (half_sel ? res[7:0] : res[15:8]);
endmodule

// File: tb/sim_byte_adc_reader.sv
module sim_byte_adc_reader;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int CONV_W     = 3;
    localparam int TIMEOUT    = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ready = 1'b0;
    logic stuck = 1'b0;
    logic [15:0] word_in = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic        act0, act1;
    logic [7:0]  dq0, dq1;
    logic        st0, sel0, oe0, hs0, v0, e0;
    logic        st1, sel1, oe1, hs1, v1, e1;
    logic [15:0] d0, d1;
    int          cc0, cc1, of0, of1, vi0, vi1, lw0, lw1;

    byte_adc_reader #(.HOLD_RD(0), .SETTLE(SETTLE), .CONV_W(CONV_W), .TIMEOUT(TIMEOUT)) u0 (
        .clk(clk), .rst(rst), .ready(ready), .conv_active(act0), .dq_hi(dq0),
        .start_n(st0), .dev_sel_n(sel0), .oe_n(oe0), .half_sel(hs0),
        .smp_valid(v0), .smp_data(d0), .tmo_err(e0));

    byte_adc_reader #(.HOLD_RD(1), .SETTLE(SETTLE), .CONV_W(CONV_W), .TIMEOUT(TIMEOUT)) u1 (
        .clk(clk), .rst(rst), .ready(ready), .conv_active(act1), .dq_hi(dq1),
        .start_n(st1), .dev_sel_n(sel1), .oe_n(oe1), .half_sel(hs1),
        .smp_valid(v1), .smp_data(d1), .tmo_err(e1));

    adc_model m0 (.clk(clk), .rst(rst), .start_n(st0), .dev_sel_n(sel0), .oe_n(oe0),
        .half_sel(hs0), .stuck(stuck), .word_in(word_in), .conv_active(act0), .dq_hi(dq0),
        .conv_cnt(cc0), .oe_falls(of0), .viol(vi0), .last_w(lw0));

    adc_model m1 (.clk(clk), .rst(rst), .start_n(st1), .dev_sel_n(sel1), .oe_n(oe1),
        .half_sel(hs1), .stuck(stuck), .word_in(word_in), .conv_active(act1), .dq_hi(dq1),
        .conv_cnt(cc1), .oe_falls(of1), .viol(vi1), .last_w(lw1));

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        // R1 during reset
        check("R1 pins in reset", {st0, sel0, oe0, hs0, v0, e0}, 6'b111000);
        rst = 1'b0;
        @(negedge clk);
        // R1 right after reset
        check("R1 pins u0 after reset", {st0, sel0, oe0, hs0, v0, e0}, 6'b111000);
        check("R1 pins u1 after reset", {st1, sel1, oe1, hs1, v1, e1}, 6'b111000);
    endtask

    task automatic t_ready_low();
        ready = 1'b0;
        repeat (30) @(negedge clk);
        // R2 nothing starts without ready
        check("R2 no conversion u0", cc0, 0);
        check("R2 no conversion u1", cc1, 0);
        check("R2 select idle", {sel0, sel1, st0, st1}, 4'b1111);
    endtask

    task automatic run_one(input logic [15:0] w, input bit expect_valid);
        int c0 = cc0;
        int r0 = of0;
        int r1 = of1;
        int pv0 = 0;
        int pv1 = 0;
        logic [15:0] g0 = '0;
        logic [15:0] g1 = '0;
        word_in = w;
        ready   = 1'b1;
        for (int i = 0; i < 100 && cc0 == c0; i++) @(negedge clk);
        ready = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (v0) begin pv0++; g0 = d0; end
            if (v1) begin pv1++; g1 = d1; end
        end
        if (expect_valid) begin
            // R8 one pulse per sample
            check("R8 valid pulse u0", pv0, 1);
            check("R8 valid pulse u1", pv1, 1);
            // R4 and R5 byte order and settle
            check("R4 R5 word u0", g0, w);
            check("R4 R5 word u1", g1, w);
        end else begin
            // R7 warm-up results dropped
            check("R7 dropped u0", pv0, 0);
            check("R7 dropped u1", pv1, 0);
        end
        // R6 strobe count per sample
        check("R6 pulse mode strobes", of0 - r0, 2);
        check("R6 held mode strobes", of1 - r1, 1);
    endtask

    task automatic t_warmup();
        for (int k = 0; k < 3; k++) run_one(16'h1111 * (k + 1), 1'b0);
        // R11 start pulse width
        check("R11 start width u0", lw0, CONV_W);
        check("R11 start width u1", lw1, CONV_W);
    endtask

    task automatic t_values();
        run_one(16'h0000, 1'b1);
        run_one(16'hFFFF, 1'b1);
        run_one(16'h8000, 1'b1);
        run_one(16'h7FFF, 1'b1);
        run_one(16'h5AC3, 1'b1);
        run_one(16'h0102, 1'b1);
    endtask

    task automatic t_timeout();
        int c0 = cc0;
        int r0 = of0;
        int r1 = of1;
        int pe0 = 0;
        int pe1 = 0;
        int pv  = 0;
        stuck = 1'b1;
        ready = 1'b1;
        for (int i = 0; i < 100 && cc0 == c0; i++) @(negedge clk);
        ready = 1'b0;
        for (int i = 0; i < TIMEOUT + 40; i++) begin
            @(negedge clk);
            if (e0) pe0++;
            if (e1) pe1++;
            if (v0 || v1) pv++;
        end
        // R9 timeout flagged once, no reads, idle again
        check("R9 tmo pulse u0", pe0, 1);
        check("R9 tmo pulse u1", pe1, 1);
        check("R9 no read u0", of0 - r0, 0);
        check("R9 no read u1", of1 - r1, 0);
        check("R9 no valid", pv, 0);
        check("R9 idle select", {sel0, sel1}, 2'b11);
        stuck = 1'b0;
        repeat (30) @(negedge clk);
        // R9 recovery
        run_one(16'h3C96, 1'b1);
    endtask

    initial begin
        t_reset();
        t_ready_low();
        t_warmup();
        t_values();
        t_timeout();
        // R3 and R10 no forbidden edges during conversion
        check("R3 R10 violations u0", vi0, 0);
        check("R3 R10 violations u1", vi1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end
endmodule